// File: doc/BRIEF.md
# Nibble-Flag Accumulator ALU

This block is the arithmetic and logic unit of a small accumulator processor. Each cycle it takes an opcode, the accumulator byte, a second operand byte, a pair of 16-bit words for the wide adds, and the current four-bit flag word. One clock edge later it presents the result, the new flag word and a write strobe. The write strobe tells the register file whether the result should be stored. The flag word holds zero (Z), subtract (N), half-carry (H) and carry (C). H tracks the carry or borrow across the low nibble, which is what a later decimal adjust needs.

Every operation follows its own flag rule. The logic operations force H and C to fixed values. Compare updates flags but never requests a write. The 8-bit increment and decrement keep C. The 16-bit register-pair add keeps Z and takes H from bit 11. The offset add onto the stack pointer forces Z and N low and takes H and C from the low byte. Any flag that an operation does not name comes straight from the flag input. When the write strobe is low, the result is zero.

Top module: `nibflag_alu`

## Requirements
- R1: ADD (opcode 0) returns acc+opb in res_o[7:0] with res_o[15:8]=0 and wr_en_o=1. It sets Z when the byte result is zero, clears N, sets H on a carry out of bit 3 and sets C on a carry out of bit 7. Flag word bit order is [3]=Z, [2]=N, [1]=H, [0]=C.
- R2: ADC (1) adds the incoming C as well. SBC (3) subtracts opb and the incoming C, sets N, and sets C when opb+C exceeds acc. Both set H from the low-nibble carry or borrow including C.
- R3: SUB (2) returns acc-opb with N=1, H on a borrow from bit 4 and C on a borrow from bit 8. CP (4) produces the same flags as SUB, but wr_en_o=0 and res_o=0.
- R4: AND (5) forces H=1 and C=0. OR (6) and XOR (7) force H=0 and C=0. All three clear N, set Z from the result and write.
- R5: INC (8) and DEC (9) act on acc. They set Z from the result and H on a nibble carry (INC) or nibble borrow (DEC). N is 0 for INC and 1 for DEC. C passes through unchanged.
- R6: ADD16 (14) returns wide_a+wide_b on all 16 bits with N=0, H from a carry out of bit 11 and C from a carry out of bit 15. Z passes through.
- R7: ADDSP (15) returns wide_a plus the sign-extended opb. It forces Z=0 and N=0 and takes H and C from carries out of bits 3 and 7 of the low-byte sum.
- R8: CPL (10) writes ~acc and sets N and H. SCF (11) sets C and clears N and H. CCF (12) inverts C and clears N and H. SCF and CCF do not write, and Z passes through for all three.
- R9: DAA (13) corrects acc to packed BCD. When N=0 it adds 0x06 if H is set or the low nibble exceeds 9, and adds 0x60 (setting C) if C is set or acc exceeds 0x99. When N=1 it subtracts 0x06 if H is set and 0x60 if C is set, and keeps C. In both cases it clears H, keeps N, sets Z from the result and writes.
- R10: Opcodes 16 to 31 pass the flag input through unchanged, with wr_en_o=0 and res_o=0.
- R11: Outputs are registered. Inputs applied before a rising edge appear on the outputs after that edge.
- R12: While rst_n is low, res_o, flags_o and wr_en_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opb_i | input | 8 | Second operand, or signed offset for ADDSP |
| wide_a_i | input | 16 | First 16-bit operand (pair or stack pointer) |
| wide_b_i | input | 16 | Second 16-bit operand for ADD16 |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| res_o | output | 16 | Result, byte results zero-extended |
| flags_o | output | 4 | New flags {Z,N,H,C} |
| wr_en_o | output | 1 | Result should be written |

## Verification
The assertions assume that every input is at a known value on each rising edge once reset is released. They also assume that the outputs checked one cycle later belong to the opcode that was applied on that edge. The bench meets this by driving every input on the falling edge, including during reset, and by holding each input set for exactly one rising edge before sampling. The flag-rule assertions compare each output against the previous cycle's opcode and flag input. For that reason the bench also exercises flag inputs whose pass-through bits differ from the forced values.

// File: rtl/nibalu_pkg.sv
package nibalu_pkg;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADC   = 5'd1,
        OP_SUB   = 5'd2,
        OP_SBC   = 5'd3,
        OP_CP    = 5'd4,
        OP_AND   = 5'd5,
        OP_OR    = 5'd6,
        OP_XOR   = 5'd7,
        OP_INC   = 5'd8,
        OP_DEC   = 5'd9,
        OP_CPL   = 5'd10,
        OP_SCF   = 5'd11,
        OP_CCF   = 5'd12,
        OP_DAA   = 5'd13,
        OP_ADD16 = 5'd14,
        OP_ADDSP = 5'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    localparam logic [1:0] LG_AND = 2'd0;
    localparam logic [1:0] LG_OR  = 2'd1;
    localparam logic [1:0] LG_XOR = 2'd2;
    localparam logic [1:0] LG_INV = 2'd3;

endpackage

// File: rtl/nibalu_addsub.sv
module nibalu_addsub #(
    parameter int W     = 8,
    parameter int NIB_W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         half_o,
    output logic         carry_o
);
    logic [W:0]     full_w;
    logic [NIB_W:0] low_w;
    logic [W:0]     cin_w;
    logic [NIB_W:0] cin_n;

    assign cin_w = {{W{1'b0}}, cin_i};
    assign cin_n = {{NIB_W{1'b0}}, cin_i};

    // Subtraction wraps, so the extra top bit is the borrow out.
    always_comb begin
        if (sub_i) begin
            full_w = {1'b0, a_i} - {1'b0, b_i} - cin_w;
            low_w  = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - cin_n;
        end else begin
            full_w = {1'b0, a_i} + {1'b0, b_i} + cin_w;
            low_w  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + cin_n;
        end
    end

    assign res_o   = full_w[W-1:0];
    assign half_o  = low_w[NIB_W];
    assign carry_o = full_w[W];
endmodule

// File: rtl/nibalu_logic.sv
module nibalu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   sel_i,
    output logic [W-1:0] res_o
);
    import nibalu_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_slice
        always_comb begin
            case (sel_i)
                LG_AND:  res_o[i] = a_i[i] & b_i[i];
                LG_OR:   res_o[i] = a_i[i] | b_i[i];
                LG_XOR:  res_o[i] = a_i[i] ^ b_i[i];
                default: res_o[i] = ~a_i[i];
            endcase
        end
    end
endmodule

// File: rtl/nibalu_daa.sv
module nibalu_daa #(
    parameter int W     = 8,
    parameter int NIB_W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic         n_i,
    input  logic         h_i,
    input  logic         c_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    localparam logic [W-1:0] LO_FIX   = W'(6);
    localparam logic [W-1:0] HI_FIX   = LO_FIX << NIB_W;
    localparam logic [W-1:0] DIGIT_MX = W'(9);
    localparam logic [W-1:0] PAIR_MX  = (DIGIT_MX << NIB_W) | DIGIT_MX;

    logic [W-1:0] adj;

    always_comb begin
        adj = '0;
        c_o = c_i;
        if (!n_i) begin
            if (c_i || (a_i > PAIR_MX)) begin
                adj = adj | HI_FIX;
                c_o = 1'b1;
            end
            if (h_i || (a_i[NIB_W-1:0] > DIGIT_MX[NIB_W-1:0])) begin
                adj = adj | LO_FIX;
            end
            res_o = a_i + adj;
        end else begin
            if (c_i) adj = adj | HI_FIX;
            if (h_i) adj = adj | LO_FIX;
            res_o = a_i - adj;
        end
    end
endmodule

// File: rtl/nibalu_wide.sv
module nibalu_wide #(
    parameter int WIDE_W = 16,
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [WIDE_W-1:0] a_i,
    input  logic [WIDE_W-1:0] b_i,
    input  logic [BYTE_W-1:0] off_i,
    input  logic              sp_mode_i,
    output logic [WIDE_W-1:0] res_o,
    output logic              half_o,
    output logic              carry_o
);
    localparam int HC_W = WIDE_W - NIB_W;

    logic [WIDE_W-1:0] off_ext;
    logic [WIDE_W-1:0] addend;
    logic [WIDE_W:0]   sum_w;
    logic [HC_W:0]     sum_hc;
    logic [BYTE_W:0]   sum_b;
    logic [NIB_W:0]    sum_n;

    assign off_ext = {{(WIDE_W-BYTE_W){off_i[BYTE_W-1]}}, off_i};
    assign addend  = sp_mode_i ? off_ext : b_i;
    assign sum_w   = {1'b0, a_i} + {1'b0, addend};
    assign sum_hc  = {1'b0, a_i[HC_W-1:0]} + {1'b0, b_i[HC_W-1:0]};
    assign sum_b   = {1'b0, a_i[BYTE_W-1:0]} + {1'b0, off_i};
    assign sum_n   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, off_i[NIB_W-1:0]};

    assign res_o   = sum_w[WIDE_W-1:0];
    assign half_o  = sp_mode_i ? sum_n[NIB_W]  : sum_hc[HC_W];
    assign carry_o = sp_mode_i ? sum_b[BYTE_W] : sum_w[WIDE_W];
endmodule

// File: rtl/nibflag_alu.sv
module nibflag_alu
    import nibalu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WIDE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [WIDE_W-1:0] wide_a_i,
    input  logic [WIDE_W-1:0] wide_b_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [WIDE_W-1:0] res_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              wr_en_o
);
    localparam int NIB_W = DATA_W / 2;
    localparam int EXT_W = WIDE_W - DATA_W;

    typedef struct packed {
        logic [WIDE_W-1:0] res;
        flags_t            fl;
        logic              wr;
    } stage_t;

    alu_op_e     op;
    flags_t      fin;
    stage_t      out_d, out_q;
    logic        live_q;

    logic [DATA_W-1:0] as_b, as_res, lg_res, daa_res;
    logic              as_cin, as_sub, as_half, as_carry, daa_c;
    logic [1:0]        lg_sel;
    logic [WIDE_W-1:0] wd_res;
    logic              wd_half, wd_carry;
    logic              is_incdec;

    assign op  = alu_op_e'(op_i);
    assign fin = flags_t'(flags_i);

    // Operand steering for the shared byte adder
    assign is_incdec = (op == OP_INC) || (op == OP_DEC);
    assign as_b      = is_incdec ? DATA_W'(1) : opb_i;
    assign as_cin    = ((op == OP_ADC) || (op == OP_SBC)) && fin.c;
    assign as_sub    = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) || (op == OP_DEC);

    always_comb begin
        case (op)
            OP_AND:  lg_sel = LG_AND;
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_INV;
        endcase
    end

    nibalu_addsub #(.W(DATA_W), .NIB_W(NIB_W)) addsub_i (
        .a_i(acc_i), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
        .res_o(as_res), .half_o(as_half), .carry_o(as_carry)
    );

    nibalu_logic #(.W(DATA_W)) logic_i (
        .a_i(acc_i), .b_i(opb_i), .sel_i(lg_sel), .res_o(lg_res)
    );

    nibalu_daa #(.W(DATA_W), .NIB_W(NIB_W)) daa_i (
        .a_i(acc_i), .n_i(fin.n), .h_i(fin.h), .c_i(fin.c),
        .res_o(daa_res), .c_o(daa_c)
    );

    nibalu_wide #(.WIDE_W(WIDE_W), .BYTE_W(DATA_W), .NIB_W(NIB_W)) wide_i (
        .a_i(wide_a_i), .b_i(wide_b_i), .off_i(opb_i),
        .sp_mode_i(op == OP_ADDSP),
        .res_o(wd_res), .half_o(wd_half), .carry_o(wd_carry)
    );

    // Next-state selection
    always_comb begin
        out_d     = '0;
        out_d.fl  = fin;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                out_d.res  = {{EXT_W{1'b0}}, as_res};
                out_d.fl.z = (as_res == '0);
                out_d.fl.n = as_sub;
                out_d.fl.h = as_half;
                out_d.fl.c = as_carry;
                out_d.wr   = 1'b1;
            end
            OP_CP: begin
                out_d.fl.z = (as_res == '0);
                out_d.fl.n = 1'b1;
                out_d.fl.h = as_half;
                out_d.fl.c = as_carry;
            end
            OP_AND, OP_OR, OP_XOR: begin
                out_d.res  = {{EXT_W{1'b0}}, lg_res};
                out_d.fl.z = (lg_res == '0);
                out_d.fl.n = 1'b0;
                out_d.fl.h = (op == OP_AND);
                out_d.fl.c = 1'b0;
                out_d.wr   = 1'b1;
            end
            OP_INC, OP_DEC: begin
                out_d.res  = {{EXT_W{1'b0}}, as_res};
                out_d.fl.z = (as_res == '0);
                out_d.fl.n = (op == OP_DEC);
                out_d.fl.h = as_half;
                out_d.wr   = 1'b1;
            end
            OP_CPL: begin
                out_d.res  = {{EXT_W{1'b0}}, lg_res};
                out_d.fl.n = 1'b1;
                out_d.fl.h = 1'b1;
                out_d.wr   = 1'b1;
            end
            OP_SCF, OP_CCF: begin
                out_d.fl.n = 1'b0;
                out_d.fl.h = 1'b0;
                out_d.fl.c = (op == OP_SCF) ? 1'b1 : ~fin.c;
            end
            OP_DAA: begin
                out_d.res  = {{EXT_W{1'b0}}, daa_res};
                out_d.fl.z = (daa_res == '0);
                out_d.fl.h = 1'b0;
                out_d.fl.c = daa_c;
                out_d.wr   = 1'b1;
            end
            OP_ADD16, OP_ADDSP: begin
                out_d.res  = wd_res;
                if (op == OP_ADDSP) out_d.fl.z = 1'b0;
                out_d.fl.n = 1'b0;
                out_d.fl.h = wd_half;
                out_d.fl.c = wd_carry;
                out_d.wr   = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            live_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            live_q <= 1'b1;
        end
    end

    assign res_o   = out_q.res;
    assign flags_o = out_q.fl;
    assign wr_en_o = out_q.wr;

    // Flag-rule checks, one cycle after the opcode was applied
    p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_ADD) |-> (flags_o[3] == (res_o == '0)));

    p_cp_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_CP) |-> (!wr_en_o && flags_o[2]));

    p_and_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_AND) |-> (flags_o[1:0] == 2'b10));

    p_incdec_keepc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
        |-> (flags_o[0] == $past(flags_i[0])));

    p_wide_keepz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_ADD16)
        |-> (flags_o[3] == $past(flags_i[3]) && !flags_o[2]));

    p_sp_zn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_ADDSP) |-> (flags_o[3:2] == 2'b00));

    p_undef_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) > 5'd15)
        |-> (flags_o == $past(flags_i) && !wr_en_o && res_o == '0));
endmodule

// File: tb/nibflag_alu_tb_top.sv
`timescale 1ns/1ps
module nibflag_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op = '0;
    logic [7:0]  acc = '0, opb = '0;
    logic [15:0] wa = '0, wb = '0;
    logic [3:0]  fl = '0;
    logic [15:0] res;
    logic [3:0]  flo;
    logic        wr;
    int          total = 0;
    int          failed = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    nibflag_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc), .opb_i(opb),
        .wide_a_i(wa), .wide_b_i(wb), .flags_i(fl),
        .res_o(res), .flags_o(flo), .wr_en_o(wr)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] x, input logic [15:0] y, input logic [3:0] f);
        @(negedge clk);
        op = o; acc = a; opb = b; wa = x; wb = y; fl = f;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [15:0] r, input logic [3:0] f, input logic w);
        chk({tag, " res"}, res, r);
        chk({tag, " flags"}, {12'h0, flo}, {12'h0, f});
        chk({tag, " wr"}, {15'h0, wr}, {15'h0, w});
    endtask

    task automatic t_reset();
        op = 5'd0; acc = 8'h12; opb = 8'h34; fl = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        expect_out("R12 reset", 16'h0000, 4'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        apply(5'd0, 8'h3A, 8'hC6, 16'h0, 16'h0, 4'h0);
        expect_out("R1 add wrap", 16'h0000, 4'hB, 1'b1);
        apply(5'd0, 8'h0F, 8'h01, 16'h0, 16'h0, 4'hD);
        expect_out("R1 add nibble", 16'h0010, 4'h2, 1'b1);
    endtask

    task automatic t_carry_ops();
        apply(5'd1, 8'hE1, 8'h0F, 16'h0, 16'h0, 4'h1);
        expect_out("R2 adc", 16'h00F1, 4'h2, 1'b1);
        apply(5'd3, 8'h3B, 8'h2A, 16'h0, 16'h0, 4'h1);
        expect_out("R2 sbc", 16'h0010, 4'h4, 1'b1);
        apply(5'd3, 8'h10, 8'h10, 16'h0, 16'h0, 4'h1);
        expect_out("R2 sbc borrow", 16'h00FF, 4'h7, 1'b1);
    endtask

    task automatic t_sub_cp();
        apply(5'd2, 8'h3E, 8'h3E, 16'h0, 16'h0, 4'h3);
        expect_out("R3 sub zero", 16'h0000, 4'hC, 1'b1);
        apply(5'd2, 8'h10, 8'h01, 16'h0, 16'h0, 4'h0);
        expect_out("R3 sub half", 16'h000F, 4'h6, 1'b1);
        apply(5'd4, 8'h3C, 8'h40, 16'h0, 16'h0, 4'h8);
        expect_out("R3 cp", 16'h0000, 4'h5, 1'b0);
    endtask

    task automatic t_logic();
        apply(5'd5, 8'hF0, 8'h0F, 16'h0, 16'h0, 4'h5);
        expect_out("R4 and", 16'h0000, 4'hA, 1'b1);
        apply(5'd6, 8'h00, 8'h00, 16'h0, 16'h0, 4'hF);
        expect_out("R4 or", 16'h0000, 4'h8, 1'b1);
        apply(5'd7, 8'h5A, 8'hFF, 16'h0, 16'h0, 4'h7);
        expect_out("R4 xor", 16'h00A5, 4'h0, 1'b1);
    endtask

    task automatic t_incdec();
        apply(5'd8, 8'hFF, 8'h77, 16'h0, 16'h0, 4'h1);
        expect_out("R5 inc", 16'h0000, 4'hB, 1'b1);
        apply(5'd9, 8'h10, 8'h77, 16'h0, 16'h0, 4'h0);
        expect_out("R5 dec half", 16'h000F, 4'h6, 1'b1);
        apply(5'd9, 8'h01, 8'h77, 16'h0, 16'h0, 4'h1);
        expect_out("R5 dec zero", 16'h0000, 4'hD, 1'b1);
    endtask

    task automatic t_wide();
        apply(5'd14, 8'h00, 8'h00, 16'h8A23, 16'h0605, 4'h8);
        expect_out("R6 add16", 16'h9028, 4'hA, 1'b1);
        apply(5'd14, 8'h00, 8'h00, 16'hFFFF, 16'h0001, 4'h4);
        expect_out("R6 add16 wrap", 16'h0000, 4'h3, 1'b1);
        apply(5'd15, 8'h00, 8'h08, 16'hFFF8, 16'h1234, 4'hC);
        expect_out("R7 addsp pos", 16'h0000, 4'h3, 1'b1);
        apply(5'd15, 8'h00, 8'hFF, 16'h1000, 16'h1234, 4'hF);
        expect_out("R7 addsp neg", 16'h0FFF, 4'h0, 1'b1);
    endtask

    task automatic t_misc();
        apply(5'd10, 8'h35, 8'h00, 16'h0, 16'h0, 4'h9);
        expect_out("R8 cpl", 16'h00CA, 4'hF, 1'b1);
        apply(5'd11, 8'h35, 8'h00, 16'h0, 16'h0, 4'h6);
        expect_out("R8 scf", 16'h0000, 4'h1, 1'b0);
        apply(5'd12, 8'h35, 8'h00, 16'h0, 16'h0, 4'h9);
        expect_out("R8 ccf set", 16'h0000, 4'h8, 1'b0);
        apply(5'd12, 8'h35, 8'h00, 16'h0, 16'h0, 4'h0);
        expect_out("R8 ccf clr", 16'h0000, 4'h1, 1'b0);
    endtask

    task automatic t_daa();
        apply(5'd13, 8'h7D, 8'h00, 16'h0, 16'h0, 4'h0);
        expect_out("R9 daa low", 16'h0083, 4'h0, 1'b1);
        apply(5'd13, 8'h9A, 8'h00, 16'h0, 16'h0, 4'h0);
        expect_out("R9 daa both", 16'h0000, 4'h9, 1'b1);
        apply(5'd13, 8'h2D, 8'h00, 16'h0, 16'h0, 4'h6);
        expect_out("R9 daa sub h", 16'h0027, 4'h4, 1'b1);
        apply(5'd13, 8'hA0, 8'h00, 16'h0, 16'h0, 4'h5);
        expect_out("R9 daa sub c", 16'h0040, 4'h5, 1'b1);
    endtask

    task automatic t_undef();
        apply(5'd20, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 4'hA);
        expect_out("R10 undefined", 16'h0000, 4'hA, 1'b0);
        apply(5'd31, 8'h01, 8'h01, 16'h0001, 16'h0001, 4'h5);
        expect_out("R10 undefined top", 16'h0000, 4'h5, 1'b0);
    endtask

    task automatic t_latency();
        // R11: new inputs driven after an edge must not show until the next edge
        apply(5'd0, 8'h01, 8'h01, 16'h0, 16'h0, 4'h0);
        @(negedge clk);
        op = 5'd0; acc = 8'h20; opb = 8'h02; fl = 4'h0;
        #1;
        chk("R11 hold before edge", res, 16'h0002);
        @(posedge clk);
        #1;
        chk("R11 update after edge", res, 16'h0022);
    endtask

    initial begin
        t_reset();
        t_add();
        t_carry_ops();
        t_sub_cp();
        t_logic();
        t_incdec();
        t_wide();
        t_misc();
        t_daa();
        t_undef();
        t_latency();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            failed++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule